// File: doc/BRIEF.md
# Round-Robin Sign-Sign Correlation Engine for Remote Equalizer Adaptation

This block sits in a serial-link receiver and works out which way each tap of the far-end transmit equalizer should move. On every accepted symbol it takes two one-bit inputs. The first is the polarity of the sliced data symbol. The second is the polarity of the slicer error. It holds a short history of data polarities and remembers the previous error polarity. It multiplies these sign terms with an XNOR and adds +1 or -1 to a single signed counter.

One correlator serves every tap. A sequencer gives it to one tap position for one block of `BLOCK_LEN` accepted symbols, then moves to the next position. The positions are visited in this order: the precursor tap, the main tap, the post-cursor tap, and then each candidate delay from 2 up to `ROVER_MAX` for the movable far tap. At the end of each block the sign of the count is latched. For the candidate delays, the block also keeps the delay whose count has the largest magnitude. Once the last candidate block ends, all latched directions and the winning delay are presented together as one adjustment message, marked by a one-cycle strobe. The next round then begins at once.

Top module: `lms_rr_engine`

## Requirements
- R1: While `rst_n` is low, `msg_valid`, `msg_dir` and `msg_rover` are all zero. After reset the sequencer starts at the precursor tap with a cleared count, so any block that was partly accumulated before reset is thrown away and produces no message.
- R2: Polarity bits use 0 for a value ≥ 0 and 1 for a negative value. For the symbol accepted at index i, the tap with offset k adds +1 when the error bit of symbol i-1 equals the data bit of symbol i-1-k, and adds -1 otherwise. The offsets are k=-1 for the precursor, k=0 for the main tap, k=1 for the post-cursor, and k=delay for a rover candidate. History bits from before reset read as 0.
- R3: Each tap position sums over exactly `BLOCK_LEN` accepted symbols, starting from zero. The running count never leaves ±`BLOCK_LEN`. A final sum of exactly zero gives an increase.
- R4: Tap positions are visited one block each, in this order: precursor, main, post-cursor, then delays 2, 3, … `ROVER_MAX`. After the last delay the order wraps back to the precursor.
- R5: A message appears only after the final candidate block. `msg_valid` is high for exactly the one cycle after the edge that accepts that block's last symbol. `msg_dir` and `msg_rover` stay unchanged between strobes.
- R6: In `msg_dir`, bit 0 is the precursor, bit 1 the main tap, bit 2 the post-cursor and bit 3 the rover tap. A 1 means increase (block sum ≥ 0) and a 0 means decrease.
- R7: `msg_rover` gives, in binary, the candidate delay with the largest absolute block sum. On a tie the smaller delay wins. Bit 3 of `msg_dir` is the direction of that winning delay.
- R8: A cycle with `sym_valid` low changes nothing: the history, the count, the block position and the sequencer all hold, whatever values `data_sgn` and `err_sgn` have.
- R9: Blocks and rounds follow each other with no symbols skipped. History carries over across block and round boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| sym_valid | input | 1 | Qualifies the current cycle as one accepted symbol |
| data_sgn | input | 1 | Polarity of the decided data symbol (1 = negative) |
| err_sgn | input | 1 | Polarity of the slicer error (1 = negative) |
| msg_valid | output | 1 | One-cycle strobe marking a new adjustment message |
| msg_dir | output | 4 | Per-tap direction bits: 0 pre, 1 main, 2 post, 3 rover; 1 = increase |
| msg_rover | output | $clog2(ROVER_MAX+1) | Chosen rover delay, in symbols |

## Verification
The case that needs care is the last candidate block. In that block the rover choice is being decided in the same cycle that the message is assembled. The bench provokes this with an error stream that echoes the data delayed by `ROVER_MAX`. Only the last candidate then reaches full magnitude, so the message must report that delay and its direction rather than the best delay stored earlier. Rounds with idle cycles inserted, with random polarities on the idle inputs, and a reset in the middle of a block are each compared against a reference sum computed in the bench from the recorded symbol streams.

// File: rtl/lms_rr_pkg.sv
package lms_rr_pkg;
  // Bit positions of the fixed taps inside the direction field of a message;
  // the rover direction always occupies the bit after the fixed taps.
  localparam int DIR_PRE   = 0;
  localparam int DIR_MAIN  = 1;
  localparam int DIR_POST  = 2;
  localparam int NUM_FIXED = 3;
  localparam int DIR_ROVER = NUM_FIXED;
  localparam int NUM_DIRS  = NUM_FIXED + 1;
  // Smallest rover delay; it follows the post-cursor offset directly, so the
  // step index doubles as the history tap select.
  localparam int ROVER_MIN = 2;
endpackage

// File: rtl/lms_hist.sv
module lms_hist #(
  parameter int HIST_LEN = 9,
  parameter int SEL_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_valid,
  input  logic             data_sgn,
  input  logic             err_sgn,
  input  logic [SEL_W-1:0] sel,
  output logic             sel_data,
  output logic             err_prev
);
  localparam int VEC_LEN = HIST_LEN + 1;

  logic [HIST_LEN-1:0] sr_q, sr_d;
  logic                err_q, err_d;
  logic [VEC_LEN-1:0]  tap_vec;

  // Next-state: shift in the current data polarity, remember this error.
  always_comb begin
    sr_d  = {sr_q[HIST_LEN-2:0], data_sgn};
    err_d = err_sgn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      err_q <= 1'b0;
    end else if (sym_valid) begin
      sr_q  <= sr_d;
      err_q <= err_d;
    end
  end

  // Entry 0 is the live data bit (offset -1); entry j is data delayed j symbols.
  always_comb begin
    tap_vec  = {sr_q, data_sgn};
    sel_data = 1'b0;
    if (int'(sel) < VEC_LEN) sel_data = tap_vec[sel];
    err_prev = err_q;
  end
endmodule

// File: rtl/lms_corr.sv
module lms_corr #(
  parameter int CNT_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sym_valid,
  input  logic                    blk_clear,
  input  logic                    agree,
  output logic signed [CNT_W-1:0] cnt_q,
  output logic signed [CNT_W-1:0] sum_next
);
  logic signed [CNT_W-1:0] cnt_d;

  always_comb begin
    sum_next = agree ? (cnt_q + CNT_W'(1)) : (cnt_q - CNT_W'(1));
    cnt_d    = blk_clear ? '0 : sum_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (sym_valid) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lms_seq.sv
module lms_seq
  import lms_rr_pkg::*;
#(
  parameter int BLOCK_LEN = 511,
  parameter int NUM_STEPS = 10,
  parameter int STEP_W    = 4,
  parameter int CNT_W     = 10,
  parameter int POS_W     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sym_valid,
  input  logic signed [CNT_W-1:0] sum_next,
  output logic [STEP_W-1:0]       step_q,
  output logic                    blk_end,
  output logic                    msg_valid,
  output logic [NUM_DIRS-1:0]     msg_dir,
  output logic [POS_W-1:0]        msg_rover
);
  localparam int SC_W       = $clog2(BLOCK_LEN + 1);
  localparam int FIRST_CAND = ROVER_MIN + 1;

  logic [SC_W-1:0]      sym_cnt_q, sym_cnt_d;
  logic [STEP_W-1:0]    step_d;
  logic [NUM_FIXED-1:0] res_q, res_d;
  logic [CNT_W-1:0]     best_mag_q, best_mag_d, mag;
  logic [POS_W-1:0]     best_pos_q, best_pos_d, cur_pos;
  logic                 best_dir_q, best_dir_d;
  logic                 msg_valid_d;
  logic [NUM_DIRS-1:0]  msg_dir_d;
  logic [POS_W-1:0]     msg_rover_d;
  logic                 last_step, sum_nonneg, is_cand, take, fire;

  // Block framing and the polarity/magnitude of the block sum.
  always_comb begin
    blk_end    = sym_valid && (sym_cnt_q == SC_W'(BLOCK_LEN - 1));
    last_step  = (step_q == STEP_W'(NUM_STEPS - 1));
    sum_nonneg = ~sum_next[CNT_W-1];
    mag        = sum_nonneg ? sum_next : (-sum_next);
    is_cand    = (step_q >= STEP_W'(FIRST_CAND));
    cur_pos    = POS_W'(step_q) - POS_W'(1);
    take       = blk_end && is_cand &&
                 ((step_q == STEP_W'(FIRST_CAND)) || (mag > best_mag_q));
    fire       = blk_end && last_step;
  end

  // Sequencer next state.
  always_comb begin
    sym_cnt_d = blk_end ? '0 : (sym_cnt_q + SC_W'(1));
    step_d    = step_q;
    if (blk_end) step_d = last_step ? '0 : (step_q + STEP_W'(1));
  end

  // Per-tap latches for the fixed taps.
  for (genvar t = 0; t < NUM_FIXED; t++) begin : g_fixed
    always_comb begin
      res_d[t] = res_q[t];
      if (blk_end && (step_q == STEP_W'(t))) res_d[t] = sum_nonneg;
    end
  end

  // Rover search: strictly larger magnitude replaces, so ties keep the
  // earlier (smaller) delay.
  always_comb begin
    best_mag_d = best_mag_q;
    best_pos_d = best_pos_q;
    best_dir_d = best_dir_q;
    if (take) begin
      best_mag_d = mag;
      best_pos_d = cur_pos;
      best_dir_d = sum_nonneg;
    end
  end

  // Message assembly; the final candidate is folded in on the same edge.
  always_comb begin
    msg_valid_d = fire;
    msg_dir_d   = msg_dir;
    msg_rover_d = msg_rover;
    if (fire) begin
      msg_dir_d[NUM_FIXED-1:0] = res_q;
      msg_dir_d[DIR_ROVER]     = best_dir_d;
      msg_rover_d              = best_pos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_cnt_q  <= '0;
      step_q     <= '0;
      res_q      <= '0;
      best_mag_q <= '0;
      best_pos_q <= '0;
      best_dir_q <= 1'b0;
    end else if (sym_valid) begin
      sym_cnt_q  <= sym_cnt_d;
      step_q     <= step_d;
      res_q      <= res_d;
      best_mag_q <= best_mag_d;
      best_pos_q <= best_pos_d;
      best_dir_q <= best_dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_dir   <= '0;
      msg_rover <= '0;
    end else begin
      msg_valid <= msg_valid_d;
      if (fire) begin
        msg_dir   <= msg_dir_d;
        msg_rover <= msg_rover_d;
      end
    end
  end
endmodule

// File: rtl/lms_rr_engine.sv
module lms_rr_engine
  import lms_rr_pkg::*;
#(
  parameter  int BLOCK_LEN = 511,
  parameter  int ROVER_MAX = 8,
  localparam int POS_W     = $clog2(ROVER_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sym_valid,
  input  logic                data_sgn,
  input  logic                err_sgn,
  output logic                msg_valid,
  output logic [NUM_DIRS-1:0] msg_dir,
  output logic [POS_W-1:0]    msg_rover
);
  localparam int NUM_STEPS = ROVER_MAX + 2;
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam int HIST_LEN  = ROVER_MAX + 1;
  localparam int CNT_W     = $clog2(BLOCK_LEN + 1) + 1;

  logic [STEP_W-1:0]       step_q;
  logic                    blk_end;
  logic                    sel_data, err_prev, agree;
  logic signed [CNT_W-1:0] corr_cnt, sum_next;

  lms_hist #(.HIST_LEN(HIST_LEN), .SEL_W(STEP_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym_valid(sym_valid),
    .data_sgn (data_sgn),
    .err_sgn  (err_sgn),
    .sel      (step_q),
    .sel_data (sel_data),
    .err_prev (err_prev)
  );

  // Sign product: equal polarities give +1.
  always_comb agree = ~(err_prev ^ sel_data);

  lms_corr #(.CNT_W(CNT_W)) u_corr (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym_valid(sym_valid),
    .blk_clear(blk_end),
    .agree    (agree),
    .cnt_q    (corr_cnt),
    .sum_next (sum_next)
  );

  lms_seq #(
    .BLOCK_LEN(BLOCK_LEN),
    .NUM_STEPS(NUM_STEPS),
    .STEP_W   (STEP_W),
    .CNT_W    (CNT_W),
    .POS_W    (POS_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym_valid(sym_valid),
    .sum_next (sum_next),
    .step_q   (step_q),
    .blk_end  (blk_end),
    .msg_valid(msg_valid),
    .msg_dir  (msg_dir),
    .msg_rover(msg_rover)
  );
endmodule

// File: rtl/lms_rr_chk.sv
module lms_rr_chk
  import lms_rr_pkg::*;
#(
  parameter  int BLOCK_LEN = 511,
  parameter  int ROVER_MAX = 8,
  localparam int POS_W     = $clog2(ROVER_MAX + 1),
  localparam int NUM_STEPS = ROVER_MAX + 2,
  localparam int STEP_W    = $clog2(NUM_STEPS),
  localparam int CNT_W     = $clog2(BLOCK_LEN + 1) + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sym_valid,
  input logic                    msg_valid,
  input logic [NUM_DIRS-1:0]     msg_dir,
  input logic [POS_W-1:0]        msg_rover,
  input logic [STEP_W-1:0]       step,
  input logic                    blk_end,
  input logic signed [CNT_W-1:0] cnt
);
  // R3: the running count stays inside one block's range.
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt) <= BLOCK_LEN) && (int'(cnt) >= -BLOCK_LEN));

  // R4: order advances by one at a block end, wraps after the last delay.
  a_r4_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && (int'(step) != NUM_STEPS - 1)) |=> (int'(step) == int'($past(step)) + 1));

  a_r4_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && (int'(step) == NUM_STEPS - 1)) |=> (step == '0));

  // R5: the strobe follows the final block end and lasts one cycle.
  a_r5_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && (int'(step) == NUM_STEPS - 1)) |=> msg_valid);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> !msg_valid);

  a_r5_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |-> ($stable(msg_dir) && $stable(msg_rover)));

  // R7: the reported delay is a legal candidate.
  a_r7_rover_range: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> ((int'(msg_rover) >= ROVER_MIN) && (int'(msg_rover) <= ROVER_MAX)));

  // R8: an idle cycle moves neither the count nor the sequencer.
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> ($stable(cnt) && $stable(step)));
endmodule

bind lms_rr_engine lms_rr_chk #(.BLOCK_LEN(BLOCK_LEN), .ROVER_MAX(ROVER_MAX)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sym_valid(sym_valid),
  .msg_valid(msg_valid),
  .msg_dir  (msg_dir),
  .msg_rover(msg_rover),
  .step     (step_q),
  .blk_end  (blk_end),
  .cnt      (corr_cnt)
);

// File: tb/tb_lms_rr_engine.sv
module tb_lms_rr_engine;
  localparam int BLK   = 16;
  localparam int RMAX  = 8;
  localparam int NSTEP = RMAX + 2;
  localparam int ROUND = BLK * NSTEP;
  localparam int DEPTH = 4096;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_valid = 1'b0;
  logic       data_sgn = 1'b0;
  logic       err_sgn = 1'b0;
  logic       msg_valid;
  logic [3:0] msg_dir;
  logic [3:0] msg_rover;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  int base   = 0;
  bit done   = 1'b0;

  logic d_arr [DEPTH];
  logic e_arr [DEPTH];

  always #5 clk = ~clk;

  lms_rr_engine #(.BLOCK_LEN(BLK), .ROVER_MAX(RMAX)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym_valid(sym_valid),
    .data_sgn (data_sgn),
    .err_sgn  (err_sgn),
    .msg_valid(msg_valid),
    .msg_dir  (msg_dir),
    .msg_rover(msg_rover)
  );

  always @(negedge clk) if (rst_n && msg_valid) pulses++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic logic gd(input int i);
    return (i < 0) ? 1'b0 : d_arr[i];
  endfunction

  function automatic logic ge(input int i);
    return (i < 0) ? 1'b0 : e_arr[i];
  endfunction

  task automatic clear_hist();
    for (int i = 0; i < DEPTH; i++) begin
      d_arr[i] = 1'b0;
      e_arr[i] = 1'b0;
    end
  endtask

  // Reference sums straight from the requirements (R2, R3, R4, R6, R7).
  task automatic model_round(output logic [3:0] dir, output int rov);
    int best = -1;
    logic rdir = 1'b0;
    dir = '0;
    rov = 0;
    for (int s = 0; s < NSTEP; s++) begin
      int sum = 0;
      int k = s - 1;
      int mag;
      for (int j = 0; j < BLK; j++) begin
        int i = base + s * BLK + j;
        sum += (ge(i - 1) == gd(i - 1 - k)) ? 1 : -1;
      end
      mag = (sum < 0) ? -sum : sum;
      if (s < 3) dir[s] = (sum >= 0);
      else if (mag > best) begin
        best = mag;
        rov  = k;
        rdir = (sum >= 0);
      end
    end
    dir[3] = rdir;
  endtask

  // Stream modes: 0 zeros, 1 alternating error, 2 echo at delay 5,
  // 3 inverted echo at delay 7, 4 echo at delay 8, 5 random,
  // 6 precursor-correlated, 7 main-correlated.
  task automatic fill(input int mode);
    for (int j = 0; j <= ROUND; j++)
      d_arr[base + j] = (mode <= 1) ? 1'b0 : 1'($urandom_range(0, 1));
    for (int j = 0; j < ROUND; j++) begin
      int i = base + j;
      case (mode)
        1:       e_arr[i] = 1'(i % 2);
        2:       e_arr[i] = gd(i - 5);
        3:       e_arr[i] = ~gd(i - 7);
        4:       e_arr[i] = gd(i - 8);
        5:       e_arr[i] = 1'($urandom_range(0, 1));
        6:       e_arr[i] = d_arr[i + 1];
        7:       e_arr[i] = d_arr[i];
        default: e_arr[i] = 1'b0;
      endcase
    end
  endtask

  task automatic send(input logic d, input logic e);
    @(negedge clk);
    sym_valid = 1'b1;
    data_sgn  = d;
    err_sgn   = e;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    sym_valid = 1'b0;
    data_sgn  = 1'($urandom_range(0, 1));
    err_sgn   = 1'($urandom_range(0, 1));
    @(posedge clk);
  endtask

  // Drives one full round and checks the message; exp_rov/exp_rdir < 0 skip
  // the hand-derived expectations.
  task automatic run_round(input string tag, input int mode, input bit gaps,
                           input int exp_rov, input int exp_rdir, input int exp_dir);
    int p0;
    logic [3:0] mdir;
    int mrov;
    logic [3:0] held_dir;
    fill(mode);
    p0 = pulses;
    for (int j = 0; j < ROUND; j++) begin
      if (gaps && (j % 3 == 2)) idle();
      send(d_arr[base + j], e_arr[base + j]);
    end
    chk("R5", {tag, " no message before final block"}, pulses - p0, 0);
    @(negedge clk);
    sym_valid = 1'b0;
    chk("R5", {tag, " strobe after last symbol"}, int'(msg_valid), 1);
    model_round(mdir, mrov);
    chk("R6", {tag, " direction field"}, int'(msg_dir), int'(mdir));
    chk("R7", {tag, " rover delay"}, int'(msg_rover), mrov);
    if (exp_rov >= 0)  chk("R7", {tag, " expected delay"}, int'(msg_rover), exp_rov);
    if (exp_rdir >= 0) chk("R6", {tag, " rover direction"}, int'(msg_dir[3]), exp_rdir);
    if (exp_dir >= 0)  chk("R3", {tag, " all directions"}, int'(msg_dir), exp_dir);
    held_dir = msg_dir;
    @(negedge clk);
    chk("R5", {tag, " strobe one cycle"}, int'(msg_valid), 0);
    chk("R5", {tag, " fields held"}, int'(msg_dir), int'(held_dir));
    base += ROUND;
  endtask

  task automatic t_reset_state();
    chk("R1", "msg_valid in reset", int'(msg_valid), 0);
    chk("R1", "msg_dir in reset", int'(msg_dir), 0);
    chk("R1", "msg_rover in reset", int'(msg_rover), 0);
  endtask

  task automatic t_tie_all_agree();
    // All sums +BLK: ties resolve to delay 2 (R7), all increase (R3).
    run_round("tie", 0, 1'b0, 2, 1, 15);
  endtask

  task automatic t_zero_sum();
    // Zero sums count as increase (R3); all rover magnitudes 0 -> delay 2.
    run_round("zero", 1, 1'b0, 2, 1, 15);
  endtask

  task automatic t_echo_gaps();
    // R8: idle cycles with random inputs must not disturb the result.
    run_round("echo5_gaps", 2, 1'b1, 5, 1, -1);
  endtask

  task automatic t_inverted_echo();
    run_round("echo7_inv", 3, 1'b0, 7, 0, -1);
  endtask

  task automatic t_last_candidate();
    // Rover decision and message assembly coincide (R7, R5).
    run_round("echo8_last", 4, 1'b0, 8, 1, -1);
  endtask

  task automatic t_fixed_taps();
    run_round("pre_corr", 6, 1'b0, -1, -1, -1);
    chk("R2", "precursor increases", int'(msg_dir[0]), 1);
    run_round("main_corr", 7, 1'b0, -1, -1, -1);
    chk("R2", "main tap increases", int'(msg_dir[1]), 1);
  endtask

  task automatic t_random_rounds();
    // R9: back-to-back rounds with continuous history.
    for (int r = 0; r < 3; r++) run_round("random", 5, (r == 1), -1, -1, -1);
  endtask

  task automatic t_reset_mid_block();
    int p0;
    fill(5);
    p0 = pulses;
    for (int j = 0; j < 40; j++) send(d_arr[base + j], e_arr[base + j]);
    @(negedge clk);
    sym_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "no message from aborted block", pulses - p0, 0);
    t_reset_state();
    rst_n = 1'b1;
    base = 0;
    clear_hist();
    // R1: a fresh full round must follow with cleared history.
    run_round("after_reset", 2, 1'b0, 5, 1, -1);
  endtask

  initial begin
    clear_hist();
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_tie_all_agree();
    t_zero_sum();
    t_echo_gaps();
    t_inverted_echo();
    t_last_candidate();
    t_fixed_taps();
    t_random_rounds();
    t_reset_mid_block();
    repeat (4) @(negedge clk);
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R5 watchdog: cycles=%0d expected<%0d", 150000, 150000);
    report();
  end
endmodule